// File: doc/BRIEF.md
# Three-Address I2C Target Front End

This block is the bus-facing half of a device that appears on an I2C bus as three separate targets. Each target address joins a fixed 4-bit type code with the same three strap pins. Three type codes are recognised, and each one steers the transaction to its own back end: a byte memory, a protection-command unit or a sensor register file. The back end that was picked is reported on `funcSel` for the length of the transaction.

SCL and SDA are oversampled by the system clock through short synchroniser chains. The block finds start and stop conditions and shifts bits most significant first. It acknowledges the address and each written byte by pulling SDA low during the ninth clock. For a write, each received byte is handed over with a one-cycle strobe. For a read, the block pulses a request in the cycle it latches `rdData`, then serialises that byte onto SDA as an open-drain driver. The block only observes SCL and never holds it low. While the memory reports a write cycle in progress, the memory address is not acknowledged.

Top module: `i2cTriTarget`

## Requirements
- R1: After a start, an address byte whose bits 7..4 equal 1010, 0110 or 0011 and whose bits 3..1 equal `strap` is acknowledged (`sdaOe` high during the ninth clock). `funcSel` then becomes 1, 2 or 3 in that order of codes, and bit 0 gives the direction (1 = read).
- R2: An address byte with any other type code, or with bits 3..1 not equal to `strap`, is not acknowledged. Following bytes up to the next start are ignored: no acknowledge, no `wrValid`, and `funcSel` stays 0.
- R3: In a write transaction, each byte is received most significant bit first and acknowledged in its ninth clock. The byte appears on `wrData` with a one-cycle `wrValid` pulse.
- R4: In a read transaction, `rdReq` pulses for one cycle and `rdData` is taken in that cycle. The byte is driven most significant bit first, with `sdaOe` high exactly for 0 bits, and `sdaOe` changes only while SCL is low.
- R5: A master acknowledge after a read byte produces a further `rdReq` and the next byte. A master no-acknowledge releases SDA and produces no further `rdReq`.
- R6: While `memBusy` is high, the memory address (type 1010) is not acknowledged and `funcSel` stays 0. The other two addresses are still acknowledged.
- R7: A repeated start with no stop before it aborts the current transaction and decodes a new address byte.
- R8: A stop (SDA rising while SCL is high) pulses `busStop` for one cycle and returns `funcSel` to 0.
- R9: During and after reset, `sdaOe`, `wrValid` and `busStop` are low and `funcSel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed SCL line |
| sdaIn | input | 1 | Sensed SDA line |
| strap | input | 3 | Address strap pins, matched against address bits 3..1 |
| memBusy | input | 1 | Memory write cycle in progress |
| rdData | input | 8 | Read byte from the selected back end, taken when `rdReq` is high |
| sdaOe | output | 1 | Pull SDA low when high (open drain) |
| funcSel | output | 2 | Selected back end: 0 none, 1 memory, 2 protection, 3 sensor |
| isRead | output | 1 | Direction of the current transaction |
| wrValid | output | 1 | One-cycle strobe for a received data byte |
| wrData | output | 8 | Received data byte |
| rdReq | output | 1 | One-cycle request for the next read byte |
| busStop | output | 1 | One-cycle pulse on a stop condition |

## Verification
The bench keeps the default parameters: two synchroniser stages and the three type codes 1010, 0110 and 0011. It drives SCL with twenty system clocks per bit. That spacing leaves room for the synchroniser latency on both edges, so the acknowledge and read-data bits can be checked in the middle of each SCL high phase. With a fixed strap of 101, the bench can flip single bits of the type code or the strap to probe mismatches. It raises `memBusy` against each address in turn, and it sends a repeated start straight after an acknowledged write byte.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [1:0] {
    FN_NONE = 2'd0,
    FN_MEM  = 2'd1,
    FN_PROT = 2'd2,
    FN_SENS = 2'd3
  } fnSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
  } dpCtrl_t;

endpackage

// File: rtl/i2cBusSync.sv
module i2cBusSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclChain;
  logic [STAGES-1:0] sdaChain;
  logic sclS, sclP, sdaP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclP     <= 1'b1;
      sdaP     <= 1'b1;
    end else begin
      sclChain <= {sclChain[STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[STAGES-2:0], sdaIn};
      sclP     <= sclS;
      sdaP     <= sdaS;
    end
  end

  assign sclS     = sclChain[STAGES-1];
  assign sdaS     = sdaChain[STAGES-1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

endmodule

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctl,
  input  logic                 sdaS,
  input  logic [BYTE_BITS-2:0] rdLow,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic [CNT_W-1:0]     bitCnt,
  output logic                 txNextBit
);

  logic [BYTE_BITS-2:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
      txReg  <= '1;
    end else begin
      if (ctl.clrCnt) begin
        bitCnt <= '0;
      end else if (ctl.shiftIn) begin
        rxByte <= {rxByte[BYTE_BITS-2:0], sdaS};
        bitCnt <= bitCnt + 1'b1;
      end
      if (ctl.loadTx) begin
        txReg <= rdLow;
      end else if (ctl.shiftTx) begin
        txReg <= {txReg[BYTE_BITS-3:0], 1'b1};
      end
    end
  end

  assign txNextBit = txReg[BYTE_BITS-2];

endmodule

// File: rtl/i2cTgtControl.sv
module i2cTgtControl
  import i2cTgtPkg::*;
#(
  parameter logic [3:0] MEM_CODE  = 4'b1010,
  parameter logic [3:0] PROT_CODE = 4'b0110,
  parameter logic [3:0] SENS_CODE = 4'b0011
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclRise,
  input  logic                 sclFall,
  input  logic                 startDet,
  input  logic                 stopDet,
  input  logic                 sdaS,
  input  logic [2:0]           strap,
  input  logic                 memBusy,
  input  logic [BYTE_BITS-1:0] rxByte,
  input  logic [CNT_W-1:0]     bitCnt,
  input  logic                 txNextBit,
  input  logic                 rdTop,
  output dpCtrl_t              ctl,
  output logic                 sdaOe,
  output fnSel_t               funcSel,
  output logic                 isRead,
  output logic                 wrValid,
  output logic                 rdReq,
  output logic                 busStop
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
  } state_t;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

  state_t state;
  fnSel_t hitSel;
  logic   masterAck;
  logic   byteDone;

  assign byteDone = sclFall && (bitCnt == LAST_BIT);

  always_comb begin
    hitSel = FN_NONE;
    if (rxByte[3:1] == strap) begin
      if (rxByte[7:4] == MEM_CODE && !memBusy) hitSel = FN_MEM;
      else if (rxByte[7:4] == PROT_CODE)       hitSel = FN_PROT;
      else if (rxByte[7:4] == SENS_CODE)       hitSel = FN_SENS;
    end
  end

  always_comb begin
    ctl.clrCnt  = startDet || (sclFall && (state == ST_AACK || state == ST_RACK ||
                                           state == ST_TACK));
    ctl.shiftIn = sclRise && (state == ST_ADDR || state == ST_RX || state == ST_TX);
    ctl.loadTx  = !startDet && !stopDet && sclFall &&
                  ((state == ST_AACK && isRead) || (state == ST_TACK && masterAck));
    ctl.shiftTx = sclFall && (state == ST_TX) && (bitCnt != LAST_BIT);
  end

  assign rdReq = ctl.loadTx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      funcSel   <= FN_NONE;
      isRead    <= 1'b0;
      sdaOe     <= 1'b0;
      wrValid   <= 1'b0;
      busStop   <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      wrValid <= 1'b0;
      busStop <= 1'b0;
      if (startDet) begin
        state   <= ST_ADDR;
        funcSel <= FN_NONE;
        sdaOe   <= 1'b0;
      end else if (stopDet) begin
        state   <= ST_IDLE;
        funcSel <= FN_NONE;
        sdaOe   <= 1'b0;
        busStop <= 1'b1;
      end else begin
        unique case (state)
          ST_ADDR: if (byteDone) begin
            if (hitSel != FN_NONE) begin
              state   <= ST_AACK;
              funcSel <= hitSel;
              isRead  <= rxByte[0];
              sdaOe   <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_AACK: if (sclFall) begin
            state <= isRead ? ST_TX : ST_RX;
            sdaOe <= isRead ? ~rdTop : 1'b0;
          end
          ST_RX: if (byteDone) begin
            state   <= ST_RACK;
            wrValid <= 1'b1;
            sdaOe   <= 1'b1;
          end
          ST_RACK: if (sclFall) begin
            state <= ST_RX;
            sdaOe <= 1'b0;
          end
          ST_TX: if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              state <= ST_TACK;
              sdaOe <= 1'b0;
            end else begin
              sdaOe <= ~txNextBit;
            end
          end
          ST_TACK: begin
            if (sclRise) masterAck <= ~sdaS;
            if (sclFall) begin
              state <= masterAck ? ST_TX : ST_IDLE;
              sdaOe <= masterAck ? ~rdTop : 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cTriTarget.sv
module i2cTriTarget
  import i2cTgtPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] MEM_CODE    = 4'b1010,
  parameter logic [3:0] PROT_CODE   = 4'b0110,
  parameter logic [3:0] SENS_CODE   = 4'b0011
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic       memBusy,
  input  logic [7:0] rdData,
  output logic       sdaOe,
  output logic [1:0] funcSel,
  output logic       isRead,
  output logic       wrValid,
  output logic [7:0] wrData,
  output logic       rdReq,
  output logic       busStop
);

  logic sdaS, sclRise, sclFall, startDet, stopDet, txNextBit;
  logic [BYTE_BITS-1:0] rxByte;
  logic [CNT_W-1:0]     bitCnt;
  dpCtrl_t ctl;
  fnSel_t  fnSel;

  i2cBusSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  i2cTgtDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaS(sdaS), .rdLow(rdData[6:0]),
    .rxByte(rxByte), .bitCnt(bitCnt), .txNextBit(txNextBit)
  );

  i2cTgtControl #(
    .MEM_CODE(MEM_CODE), .PROT_CODE(PROT_CODE), .SENS_CODE(SENS_CODE)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .strap(strap),
    .memBusy(memBusy), .rxByte(rxByte), .bitCnt(bitCnt), .txNextBit(txNextBit),
    .rdTop(rdData[7]), .ctl(ctl), .sdaOe(sdaOe), .funcSel(fnSel), .isRead(isRead),
    .wrValid(wrValid), .rdReq(rdReq), .busStop(busStop)
  );

  assign funcSel = fnSel;
  assign wrData  = rxByte;

endmodule

// File: rtl/i2cTriTargetChk.sv
module i2cTriTargetChk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       memBusy,
  input logic       sdaOe,
  input logic [1:0] funcSel,
  input logic       isRead,
  input logic       wrValid,
  input logic       rdReq,
  input logic       busStop
);

  AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (funcSel != 2'd0 && !isRead)); // R3
  AST_NO_WR_RD_MIX: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && rdReq)); // R3
  AST_RD_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (isRead && funcSel != 2'd0)); // R4
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn); // R4
  AST_BUSY_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 2'd1 && $past(funcSel) != 2'd1) |-> !$past(memBusy)); // R6
  AST_STOP_DESELECTS: assert property (@(posedge clk) disable iff (!rstN)
    busStop |-> funcSel == 2'd0); // R8

endmodule

bind i2cTriTarget i2cTriTargetChk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .memBusy(memBusy), .sdaOe(sdaOe),
  .funcSel(funcSel), .isRead(isRead), .wrValid(wrValid), .rdReq(rdReq),
  .busStop(busStop)
);

// File: tb/test_i2cTriTarget.sv
module test_i2cTriTarget;

  localparam int HALF = 5;  // system clocks per quarter SCL period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic memBusy = 1'b0;
  logic [7:0] rdData;
  logic sdaOe, isRead, wrValid, rdReq, busStop;
  logic [1:0] funcSel;
  logic [7:0] wrData;
  wire sdaBus = sdaM & ~sdaOe;

  int tests = 0, fails = 0;
  int rdIdx = 0, rdCnt = 0, wrCnt = 0, stopCnt = 0, expK = 0;
  bit rdSeen = 0, done = 0;
  logic [7:0] wrQ[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] rdVal(input int k);
    return 8'h3C ^ 8'(k * 41);
  endfunction

  assign rdData = rdVal(rdIdx);

  i2cTriTarget i_i2cTriTarget (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .strap(strap),
    .memBusy(memBusy), .rdData(rdData), .sdaOe(sdaOe), .funcSel(funcSel),
    .isRead(isRead), .wrValid(wrValid), .wrData(wrData), .rdReq(rdReq),
    .busStop(busStop)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model for the back-end side
  always @(negedge clk) begin
    if (busStop) stopCnt++;
    if (rdReq) rdSeen <= 1'b1;
    else if (rdSeen) begin rdSeen <= 1'b0; rdIdx <= rdIdx + 1; rdCnt++; end
    if (wrValid) begin
      wrCnt++;
      if (wrQ.size() == 0) chk(0, "R3 unexpected write strobe", wrData, 0);
      else begin
        logic [7:0] e;
        e = wrQ.pop_front();
        chk(wrData == e, "R3 write byte", wrData, e);
      end
    end
  end

  task automatic busStart();
    tick(HALF); sdaM = 1'b1; tick(HALF); scl = 1'b1;
    tick(2*HALF); sdaM = 1'b0; tick(2*HALF); scl = 1'b0;
  endtask

  task automatic busStopSeq();
    tick(HALF); sdaM = 1'b0; tick(HALF); scl = 1'b1;
    tick(2*HALF); sdaM = 1'b1; tick(2*HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    for (int i = 7; i >= 0; i--) begin
      tick(HALF); sdaM = b[i]; tick(HALF); scl = 1'b1;
      tick(HALF);
      if (sdaOe) chk(0, {tag, " target drove during master bit"}, sdaOe, 0);
      tick(HALF); scl = 1'b0;
    end
    tick(HALF); sdaM = 1'b1; tick(HALF); scl = 1'b1;
    tick(HALF); chk(sdaOe == expAck, {tag, " ack"}, sdaOe, expAck);
    tick(HALF); scl = 1'b0;
  endtask

  task automatic recvByte(input logic [7:0] e, input logic ack, input string tag);
    for (int i = 7; i >= 0; i--) begin
      tick(HALF); sdaM = 1'b1; tick(HALF); scl = 1'b1;
      tick(HALF);
      if (sdaBus !== e[i]) chk(0, {tag, " read bit"}, sdaBus, e[i]);
      tick(HALF); scl = 1'b0;
    end
    tests++;
    tick(HALF); sdaM = ~ack; tick(HALF); scl = 1'b1;
    tick(2*HALF); scl = 1'b0;
  endtask

  initial begin
    tick(5);
    chk(sdaOe == 0, "R9 sdaOe in reset", sdaOe, 0);
    chk(funcSel == 0 && !wrValid && !busStop, "R9 outputs in reset", funcSel, 0);
    rstN = 1'b1;
    tick(5);
    chk(funcSel == 0 && sdaOe == 0, "R9 after reset", funcSel, 0);

    // memory write
    busStart();
    sendByte({4'b1010, 3'b101, 1'b0}, 1, "R1 memory address");
    chk(funcSel == 1, "R1 memory select", funcSel, 1);
    wrQ.push_back(8'h5A); sendByte(8'h5A, 1, "R3 byte 0");
    wrQ.push_back(8'hC3); sendByte(8'hC3, 1, "R3 byte 1");
    busStopSeq();
    chk(funcSel == 0, "R8 deselect on stop", funcSel, 0);
    chk(stopCnt == 1, "R8 stop pulse", stopCnt, 1);
    chk(wrCnt == 2, "R3 write count", wrCnt, 2);

    // protection write
    busStart();
    sendByte({4'b0110, 3'b101, 1'b0}, 1, "R1 protection address");
    chk(funcSel == 2 && !isRead, "R1 protection select", funcSel, 2);
    wrQ.push_back(8'h11); sendByte(8'h11, 1, "R3 protection byte");
    busStopSeq();

    // sensor read, ack then nack
    busStart();
    sendByte({4'b0011, 3'b101, 1'b1}, 1, "R1 sensor address");
    chk(funcSel == 3 && isRead, "R1 sensor read select", funcSel, 3);
    recvByte(rdVal(expK), 1, "R4 first byte"); expK++;
    recvByte(rdVal(expK), 0, "R5 second byte"); expK++;
    tick(30);
    chk(rdCnt == 2, "R5 read requests", rdCnt, 2);
    chk(sdaOe == 0, "R5 released after nack", sdaOe, 0);
    busStopSeq();

    // strap mismatch
    busStart();
    sendByte({4'b1010, 3'b100, 1'b0}, 0, "R2 strap mismatch");
    sendByte(8'hFF, 0, "R2 ignored byte");
    chk(funcSel == 0 && wrCnt == 3, "R2 nothing selected", funcSel, 0);
    busStopSeq();

    // type mismatch
    busStart();
    sendByte({4'b0111, 3'b101, 1'b0}, 0, "R2 type mismatch");
    chk(funcSel == 0, "R2 type not selected", funcSel, 0);
    busStopSeq();

    // memory busy
    memBusy = 1'b1;
    busStart();
    sendByte({4'b1010, 3'b101, 1'b0}, 0, "R6 busy memory");
    chk(funcSel == 0, "R6 memory not selected", funcSel, 0);
    busStopSeq();
    busStart();
    sendByte({4'b0011, 3'b101, 1'b0}, 1, "R6 sensor while busy");
    chk(funcSel == 3, "R6 sensor selected", funcSel, 3);
    busStopSeq();
    memBusy = 1'b0;

    // repeated start
    busStart();
    sendByte({4'b1010, 3'b101, 1'b0}, 1, "R7 first address");
    wrQ.push_back(8'h77); sendByte(8'h77, 1, "R7 first byte");
    busStart();
    sendByte({4'b0011, 3'b101, 1'b1}, 1, "R7 second address");
    chk(funcSel == 3 && isRead, "R7 reselect", funcSel, 3);
    recvByte(rdVal(expK), 0, "R7 read byte"); expK++;
    busStopSeq();

    tick(10);
    chk(wrQ.size() == 0, "R3 all writes seen", wrQ.size(), 0);
    chk(rdCnt == expK, "R5 total read requests", rdCnt, expK);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule